// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of an 8-bit successive approximation analog-to-digital converter. A requester raises a conversion request once the analog input has been captured. The controller then places a sequence of trial codes on an output bus that feeds an external D-to-A converter. An external comparator answers each trial with a single bit that says whether the trial code is above the held input.

The controller settles one bit per clock, starting at the most significant bit. When the least significant bit has been decided, it presents the finished code and raises a done flag. The done flag stays up for as long as the request stays high. It drops once the requester releases the request, which completes a four-phase handshake. A request line that is left high never starts a second conversion by itself.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `trial_code`, `result` and `done` to zero and leaves the controller ready but not armed.
- R2: A conversion is accepted only on a rising clock edge where `conv_req` is 1, the controller is ready, and `conv_req` has been sampled 0 at least once since reset or since the last conversion was released. A request held high through reset starts nothing.
- R3: On the clock after the accepting edge, `trial_code` equals midscale, 8'h80 (only bit 7 set).
- R4: Each step lasts one clock. At the following edge `cmp_high` is sampled. A value of 1 means the trial is above the input, so the bit under test is cleared; a value of 0 means the bit is kept. The next lower bit is then set to 1. Bits above the bit under test do not change.
- R5: `done` rises 8 clocks after the accepting edge. In that same cycle `result` holds the final code, and `trial_code` also shows it. When the comparator answers truthfully, the final code is the largest code that is not above the input.
- R6: While `done` is 1 and `conv_req` stays 1, `done` stays 1 and `result` stays stable.
- R7: `done` clears on the first edge at which `conv_req` is sampled 0 in the done state. The controller is then ready and armed, and a new request is accepted.
- R8: Dropping `conv_req` during a conversion does not abort it. The conversion runs to the end, and `done` is then high for exactly one cycle.
- R9: `result` keeps the last finished code after `done` clears, until the next conversion finishes or a reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_req | input | 1 | Conversion request, four-phase handshake with `done` |
| cmp_high | input | 1 | Comparator answer: 1 when the trial code is above the input |
| done | output | 1 | End of conversion; `result` is valid while it is 1 |
| result | output | 8 | Finished conversion code |
| trial_code | output | 8 | Trial code driven to the external D-to-A converter |

## Verification
The accepting edge is the reference point. Midscale appears one clock after it, each comparator answer takes effect one clock after its trial code is shown, and `done` with the final code arrives eight clocks after it. `done` clears one clock after the request is seen low. The bench drives inputs and samples outputs on falling edges, and it counts falling edges from the request: midscale is checked at the first, a low `done` at the eighth, and the finished code at the ninth. A behavioural model advanced on every rising edge is compared with all three outputs on every falling edge. Its comparator answers from the model's own trial code, so the expected result for any input code is that code itself.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    localparam int unsigned SARC_DEF_W = 8;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_CONV  = 2'd1,
        ST_DONE  = 2'd2
    } sarc_state_e;

    typedef struct packed {
        logic load;   // accept a new request, place midscale
        logic step;   // one comparison step this cycle
        logic last;   // this step decides bit 0
        logic drop;   // done state and request released
    } sarc_ctrl_t;

    function automatic int unsigned sarc_idx_w(input int unsigned w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/sarc_seq.sv
module sarc_seq
    import sarc_pkg::*;
#(
    parameter int unsigned W  = SARC_DEF_W,
    parameter int unsigned IW = sarc_idx_w(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_req,
    output sarc_ctrl_t    ctrl,
    output logic [IW-1:0] bit_idx
);

    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    sarc_state_e   st;
    logic          armed;
    logic [IW-1:0] idx;

    always_comb begin
        ctrl.load = (st == ST_READY) && armed && conv_req;
        ctrl.step = (st == ST_CONV);
        ctrl.last = (st == ST_CONV) && (idx == '0);
        ctrl.drop = (st == ST_DONE) && !conv_req;
    end

    assign bit_idx = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_READY;
            armed <= 1'b0;
            idx   <= TOP_IDX;
        end else begin
            unique case (st)
                ST_READY: begin
                    if (!conv_req) begin
                        armed <= 1'b1;
                    end else if (armed) begin
                        armed <= 1'b0;
                        idx   <= TOP_IDX;
                        st    <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (idx == '0) begin
                        st <= ST_DONE;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!conv_req) begin
                        armed <= 1'b1;
                        st    <= ST_READY;
                    end
                end
                default: st <= ST_READY;
            endcase
        end
    end

endmodule

// File: rtl/sarc_sar.sv
module sarc_sar
    import sarc_pkg::*;
#(
    parameter int unsigned W  = SARC_DEF_W,
    parameter int unsigned IW = sarc_idx_w(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  sarc_ctrl_t    ctrl,
    input  logic [IW-1:0] bit_idx,
    input  logic          cmp_high,
    output logic [W-1:0]  trial,
    output logic [W-1:0]  next_code
);

    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    function automatic logic [W-1:0] settle_bit(
        input logic [W-1:0]  cur,
        input logic [IW-1:0] k,
        input logic          above
    );
        logic [W-1:0] r;
        r    = cur;
        r[k] = !above;
        if (k != '0) begin
            r[k - 1'b1] = 1'b1;
        end
        return r;
    endfunction

    assign next_code = settle_bit(trial, bit_idx, cmp_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            trial <= '0;
        end else if (ctrl.load) begin
            trial <= MID;
        end else if (ctrl.step) begin
            trial <= next_code;
        end
    end

endmodule

// File: rtl/sarc_out.sv
module sarc_out
    import sarc_pkg::*;
#(
    parameter int unsigned W = SARC_DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sarc_ctrl_t   ctrl,
    input  logic [W-1:0] next_code,
    output logic         done,
    output logic [W-1:0] result
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
        end else if (ctrl.last) begin
            done   <= 1'b1;
            result <= next_code;
        end else if (ctrl.drop) begin
            done   <= 1'b0;
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sarc_pkg::*;
#(
    parameter int unsigned W = SARC_DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         conv_req,
    input  logic         cmp_high,
    output logic         done,
    output logic [W-1:0] result,
    output logic [W-1:0] trial_code
);

    localparam int unsigned IW = sarc_idx_w(W);

    sarc_ctrl_t    seq_ctrl;
    logic [IW-1:0] seq_idx;
    logic [W-1:0]  sar_next;

    sarc_seq #(.W(W), .IW(IW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .conv_req (conv_req),
        .ctrl     (seq_ctrl),
        .bit_idx  (seq_idx)
    );

    sarc_sar #(.W(W), .IW(IW)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (seq_ctrl),
        .bit_idx   (seq_idx),
        .cmp_high  (cmp_high),
        .trial     (trial_code),
        .next_code (sar_next)
    );

    sarc_out #(.W(W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (seq_ctrl),
        .next_code (sar_next),
        .done      (done),
        .result    (result)
    );

endmodule

// File: rtl/sarc_chk.sv
module sarc_chk
    import sarc_pkg::*;
#(
    parameter int unsigned W = SARC_DEF_W
) (
    input logic         clk,
    input logic         rst,
    input logic         conv_req,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] trial_code,
    input sarc_ctrl_t   ctrl
);

    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    AST_LOAD_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        ctrl.load |=> (trial_code == MID)); // R3

    AST_STEP_TOUCHES_TWO: assert property (@(posedge clk) disable iff (rst)
        ctrl.step |=> ($countones(trial_code ^ $past(trial_code)) <= 2)); // R4

    AST_LAST_RAISES_DONE: assert property (@(posedge clk) disable iff (rst)
        ctrl.last |=> done); // R5

    AST_DONE_SHOWS_CODE: assert property (@(posedge clk) disable iff (rst)
        done |-> (trial_code == result)); // R5

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && conv_req) |=> (done && $stable(result))); // R6

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (done && !conv_req) |=> !done); // R7

    AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!done && !ctrl.last) |=> $stable(result)); // R9

endmodule

bind sar_adc_ctrl sarc_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_req   (conv_req),
    .done       (done),
    .result     (result),
    .trial_code (trial_code),
    .ctrl       (seq_ctrl)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       conv_req;
    logic [7:0] vin_code;
    logic       cmp_high;
    logic       done;
    logic [7:0] result;
    logic [7:0] trial_code;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    // comparator: 1 when the trial code is above the held input
    assign cmp_high = (trial_code > vin_code);

    sar_adc_ctrl #(.W(8)) u0 (
        .clk        (clk),
        .rst        (rst),
        .conv_req   (conv_req),
        .cmp_high   (cmp_high),
        .done       (done),
        .result     (result),
        .trial_code (trial_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 converting, 2 finished
    int  m_phase = 0;
    int  m_trial = 0;
    int  m_res   = 0;
    int  m_done  = 0;
    int  m_armed = 0;
    int  m_k     = 0;
    bit  m_live  = 0;

    always @(posedge clk) begin
        cyc++;
        m_live = 1;
        if (rst) begin
            m_phase = 0; m_trial = 0; m_res = 0; m_done = 0; m_armed = 0;
        end else if (m_phase == 0) begin
            if (!conv_req) m_armed = 1;
            else if (m_armed == 1) begin
                m_armed = 0; m_phase = 1; m_trial = 128; m_k = 7;
            end
        end else if (m_phase == 1) begin
            if (m_trial > int'(vin_code)) m_trial = m_trial - (1 << m_k);
            if (m_k > 0) begin
                m_trial = m_trial + (1 << (m_k - 1));
                m_k--;
            end else begin
                m_res = m_trial; m_done = 1; m_phase = 2;
            end
        end else begin
            if (!conv_req) begin
                m_done = 0; m_phase = 0; m_armed = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk(int'(trial_code) == m_trial, "R4 trial_code vs model", int'(trial_code), m_trial);
            chk(int'(done) == m_done, "R7 done vs model", int'(done), m_done);
            chk(int'(result) == m_res, "R5 result vs model", int'(result), m_res);
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog R5 actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic convert(input logic [7:0] v);
        @(negedge clk);
        vin_code = v;
        conv_req = 1'b1;
        @(negedge clk);
        chk(trial_code == 8'h80, "R3 midscale", int'(trial_code), 128);
        repeat (7) @(negedge clk);
        chk(done == 1'b0, "R5 done not early", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R5 done latency", int'(done), 1);
        chk(result == v, "R5 final code", int'(result), int'(v));
        chk(trial_code == v, "R5 trial shows code", int'(trial_code), int'(v));
        repeat (4) @(negedge clk);
        chk(done == 1'b1 && result == v, "R6 done held", int'(result), int'(v));
        conv_req = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7 done released", int'(done), 0);
        chk(result == v, "R9 result kept", int'(result), int'(v));
    endtask

    initial begin
        rst      = 1'b1;
        conv_req = 1'b1;
        vin_code = 8'd77;
        repeat (3) @(negedge clk);
        chk(trial_code == 0 && result == 0 && done == 0, "R1 reset state",
            int'(trial_code) + int'(result) + int'(done), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(done == 1'b0 && trial_code == 8'h00, "R2 held request ignored", int'(trial_code), 0);
        conv_req = 1'b0;
        @(negedge clk);

        convert(8'd0);
        convert(8'd255);
        convert(8'd128);
        convert(8'd127);
        convert(8'hA5);
        convert(8'h5A);
        convert(8'd1);
        for (int i = 0; i < 6; i++) begin
            convert(8'((i * 53 + 19) % 256));
        end

        // R7: request raised again right after release is accepted
        convert(8'd200);

        // R8: short request, conversion still completes
        @(negedge clk);
        vin_code = 8'd99;
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        repeat (7) @(negedge clk);
        chk(done == 1'b0, "R8 done not early", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1 && result == 8'd99, "R8 completes", int'(result), 99);
        @(negedge clk);
        chk(done == 1'b0, "R8 one-cycle done", int'(done), 0);
        chk(result == 8'd99, "R9 result kept after pulse", int'(result), 99);

        // R1: reset in the middle of a conversion
        @(negedge clk);
        vin_code = 8'd60;
        conv_req = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(trial_code == 0 && result == 0 && done == 0, "R1 mid-conversion reset",
            int'(trial_code) + int'(result), 0);
        rst      = 1'b0;
        conv_req = 1'b0;
        @(negedge clk);
        convert(8'd60);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule